// File: doc/BRIEF.md
# User access override control unit

This unit keeps a one-bit override flag that decides whether the unprivileged load and store instructions run with user permissions or with the permissions of the current exception level. It also decodes the system-register instructions that reach the flag: a register read, a register write from a 64-bit operand, and an immediate-form write. It does not trap; it raises an undefined-instruction flag that the pipeline acts on.

The flag is held in a two-state machine with the states `OVR_CLEAR` and `OVR_SET`. The transition `SET_FLAG` moves from `OVR_CLEAR` to `OVR_SET` on an accepted write of 1. The transition `CLEAR_FLAG` moves back on an accepted write of 0. Every other cycle holds the state. The "treat as privileged" output is combinational. It is formed from the exception level, the hypervisor host-mode bits and the current state. A parameter `FEAT_EN` removes the flag altogether. When it is cleared, every matching access is undefined.

The access kind is encoded on two bits: 0 is a register read, 1 is a register write, 2 is an immediate write and 3 means no access.

Top module: `uao_ctrl`

## Requirements
- R1: A register read or register write matches only when op0=3, op1=0, CRn=4, CRm=2 and op2=4. A non-matching access has no effect on the flag, does not raise undefined and returns zero read data.
- R2: An immediate write (kind 2) matches only when op0=0, op1=0, CRn=4 and op2=3. The new flag value is taken from CRm bit 0.
- R3: Any matching access at exception level 0 raises `undef_o` in the same cycle and leaves the flag unchanged.
- R4: A matching read at levels 1 to 3 returns the flag at bit 23 and zero in all other bits. In every other case read data is zero.
- R5: A matching register write at levels 1 to 3 loads the flag from operand bit 23, and the other operand bits are ignored. The new value is visible from the next cycle; in the cycle of the write, the outputs still reflect the old value.
- R6: `priv_o` is 0 at level 0 and equals the flag at level 1.
- R7: At level 2, `priv_o` equals the flag when E2H and TGE are both 1, and is 1 otherwise.
- R8: At level 3, `priv_o` is 1 regardless of the flag.
- R9: With `FEAT_EN`=0, every matching access raises `undef_o`, read data stays zero and the flag behaves as 0.
- R10: Reset clears the flag (state `OVR_CLEAR`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| el_i | input | 2 | Current exception level 0..3 |
| e2h_i | input | 1 | Hypervisor host-extension enable bit |
| tge_i | input | 1 | Hypervisor trap-general-exceptions bit |
| acc_kind_i | input | 2 | 0 read, 1 register write, 2 immediate write, 3 none |
| op0_i | input | 2 | Instruction op0 field |
| op1_i | input | 3 | Instruction op1 field |
| crn_i | input | 4 | Instruction CRn field |
| crm_i | input | 4 | Instruction CRm field |
| op2_i | input | 3 | Instruction op2 field |
| wdata_i | input | 64 | Write operand for register writes |
| rdata_o | output | 64 | Read data |
| undef_o | output | 1 | Undefined-instruction flag for this access |
| priv_o | output | 1 | Unprivileged load/store acts as privileged |

## Verification
A wrong state in this unit can only appear in two places. One is `priv_o` at level 1 or at level 2 in host mode. The other is bit 23 of a read. Both show it in the cycle after the faulty update. The bench therefore follows every write with a read and a level-1 observation of `priv_o`. It also checks that level 3 and non-host level 2 mask the flag entirely. Ignored accesses are covered in the same way: writes at level 0, writes with a wrong encoding and stray operand bits are each followed by a read of the flag.

// File: rtl/uao_pkg.sv
package uao_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_IMM   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        OVR_CLEAR = 1'b0,
        OVR_SET   = 1'b1
    } ovr_state_e;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned FLAG_POS = 23;

endpackage

// File: rtl/uao_decode.sv
module uao_decode
    import uao_pkg::*;
#(
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned FLAG_BIT = FLAG_POS,
    parameter bit          FEAT_EN  = 1'b1
) (
    input  logic [1:0]    el_i,
    input  acc_kind_e     kind_i,
    input  logic [1:0]    op0_i,
    input  logic [2:0]    op1_i,
    input  logic [3:0]    crn_i,
    input  logic [3:0]    crm_i,
    input  logic [2:0]    op2_i,
    input  logic [DW-1:0] wdata_i,
    output logic          rd_hit_o,
    output logic          wr_en_o,
    output logic          wr_val_o,
    output logic          undef_o
);

    logic reg_enc;
    logic imm_enc;
    logic hit;
    logic allowed;
    logic wdata_unused;

    assign reg_enc = (op0_i == 2'b11) && (op1_i == 3'b000) && (crn_i == 4'b0100)
                  && (crm_i == 4'b0010) && (op2_i == 3'b100);
    assign imm_enc = (op0_i == 2'b00) && (op1_i == 3'b000) && (crn_i == 4'b0100)
                  && (op2_i == 3'b011);

    always_comb begin
        unique case (kind_i)
            ACC_READ,
            ACC_WRITE: hit = reg_enc;
            ACC_IMM:   hit = imm_enc;
            default:   hit = 1'b0;
        endcase
    end

    assign allowed  = FEAT_EN && (el_i != 2'd0);
    assign undef_o  = hit && !allowed;
    assign rd_hit_o = hit && allowed && (kind_i == ACC_READ);
    assign wr_en_o  = hit && allowed && (kind_i != ACC_READ);
    assign wr_val_o = (kind_i == ACC_IMM) ? crm_i[0] : wdata_i[FLAG_BIT];

    assign wdata_unused = ^wdata_i;

endmodule

// File: rtl/uao_state.sv
module uao_state
    import uao_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_val_i,
    output logic flag_o
);

    ovr_state_e state_q;
    ovr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OVR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_CLEAR: if (wr_en_i && wr_val_i)  state_d = OVR_SET;
            OVR_SET:   if (wr_en_i && !wr_val_i) state_d = OVR_CLEAR;
            default:   state_d = OVR_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OVR_SET: flag_o = 1'b1;
            default: flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/uao_priv.sv
module uao_priv (
    input  logic [1:0] el_i,
    input  logic       e2h_i,
    input  logic       tge_i,
    input  logic       flag_i,
    output logic       priv_o
);

    logic host_mode;

    assign host_mode = e2h_i && tge_i;

    always_comb begin
        unique case (el_i)
            2'd0:    priv_o = 1'b0;
            2'd1:    priv_o = flag_i;
            2'd2:    priv_o = host_mode ? flag_i : 1'b1;
            default: priv_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/uao_ctrl.sv
module uao_ctrl
    import uao_pkg::*;
#(
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned FLAG_BIT = FLAG_POS,
    parameter bit          FEAT_EN  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    el_i,
    input  logic          e2h_i,
    input  logic          tge_i,
    input  logic [1:0]    acc_kind_i,
    input  logic [1:0]    op0_i,
    input  logic [2:0]    op1_i,
    input  logic [3:0]    crn_i,
    input  logic [3:0]    crm_i,
    input  logic [2:0]    op2_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          undef_o,
    output logic          priv_o
);

    acc_kind_e kind;
    logic      rd_hit;
    logic      wr_en;
    logic      wr_val;
    logic      flag_q;

    assign kind = acc_kind_e'(acc_kind_i);

    uao_decode #(
        .DW       (DW),
        .FLAG_BIT (FLAG_BIT),
        .FEAT_EN  (FEAT_EN)
    ) u_decode (
        .el_i     (el_i),
        .kind_i   (kind),
        .op0_i    (op0_i),
        .op1_i    (op1_i),
        .crn_i    (crn_i),
        .crm_i    (crm_i),
        .op2_i    (op2_i),
        .wdata_i  (wdata_i),
        .rd_hit_o (rd_hit),
        .wr_en_o  (wr_en),
        .wr_val_o (wr_val),
        .undef_o  (undef_o)
    );

    generate
        if (FEAT_EN) begin : g_flag
            uao_state u_state (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en_i  (wr_en),
                .wr_val_i (wr_val),
                .flag_o   (flag_q)
            );
        end else begin : g_no_flag
            logic wr_unused;
            assign wr_unused = wr_en ^ wr_val;
            assign flag_q    = 1'b0;
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        rdata_o[FLAG_BIT] = rd_hit && flag_q;
    end

    uao_priv u_priv (
        .el_i   (el_i),
        .e2h_i  (e2h_i),
        .tge_i  (tge_i),
        .flag_i (flag_q),
        .priv_o (priv_o)
    );

endmodule

// File: rtl/uao_ctrl_chk.sv
module uao_ctrl_chk #(
    parameter int unsigned DW       = 64,
    parameter int unsigned FLAG_BIT = 23,
    parameter bit          FEAT_EN  = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    el_i,
    input logic          e2h_i,
    input logic          tge_i,
    input logic [1:0]    acc_kind_i,
    input logic [1:0]    op0_i,
    input logic [2:0]    op1_i,
    input logic [3:0]    crn_i,
    input logic [3:0]    crm_i,
    input logic [2:0]    op2_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] rdata_o,
    input logic          undef_o,
    input logic          priv_o,
    input logic          flag_q
);

    logic reg_match;
    logic any_match;

    assign reg_match = (acc_kind_i == 2'd0 || acc_kind_i == 2'd1)
                    && op0_i == 2'd3 && op1_i == 3'd0 && crn_i == 4'd4
                    && crm_i == 4'd2 && op2_i == 3'd4;
    assign any_match = reg_match || (acc_kind_i == 2'd2 && op0_i == 2'd0
                    && op1_i == 3'd0 && crn_i == 4'd4 && op2_i == 3'd3);

    // R3
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_match && el_i == 2'd0) |-> undef_o);

    // R3
    el0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_i == 2'd0 && acc_kind_i != 2'd3) |=> $stable(flag_q));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~(DW'(1) << FLAG_BIT)) == '0);

    // R5
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FEAT_EN && reg_match && acc_kind_i == 2'd1 && el_i != 2'd0)
        |=> flag_q == $past(wdata_i[FLAG_BIT]));

    // R1
    no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_match |=> $stable(flag_q));

    // R8
    el3_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_i == 2'd3) |-> priv_o);

    // R7
    el2_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_i == 2'd2 && !(e2h_i && tge_i)) |-> priv_o);

    // R9
    absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!FEAT_EN && any_match) |-> (undef_o && rdata_o == '0));

endmodule

bind uao_ctrl uao_ctrl_chk #(
    .DW       (DW),
    .FLAG_BIT (FLAG_BIT),
    .FEAT_EN  (FEAT_EN)
) u_chk (.*);

// File: tb/test_uao_ctrl.sv
module test_uao_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  el_i = '0;
    logic        e2h_i = 1'b0;
    logic        tge_i = 1'b0;
    logic [1:0]  acc_kind_i = 2'd3;
    logic [1:0]  op0_i = '0;
    logic [2:0]  op1_i = '0;
    logic [3:0]  crn_i = '0;
    logic [3:0]  crm_i = '0;
    logic [2:0]  op2_i = '0;
    logic [63:0] wdata_i = '0;
    logic [63:0] rdata_o, rdata_off;
    logic        undef_o, undef_off;
    logic        priv_o, priv_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uao_ctrl i_uao_ctrl (
        .clk(clk), .rst_n(rst_n), .el_i(el_i), .e2h_i(e2h_i), .tge_i(tge_i),
        .acc_kind_i(acc_kind_i), .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i),
        .crm_i(crm_i), .op2_i(op2_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .undef_o(undef_o), .priv_o(priv_o)
    );

    uao_ctrl #(.FEAT_EN(1'b0)) i_uao_ctrl_off (
        .clk(clk), .rst_n(rst_n), .el_i(el_i), .e2h_i(e2h_i), .tge_i(tge_i),
        .acc_kind_i(acc_kind_i), .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i),
        .crm_i(crm_i), .op2_i(op2_i), .wdata_i(wdata_i),
        .rdata_o(rdata_off), .undef_o(undef_off), .priv_o(priv_off)
    );

    // fields: el, e2h, tge, kind, enc_ok, val, exp_undef, exp_rbit, exp_priv
    localparam int NV = 19;
    localparam logic [10:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 R6 read 0
        {2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 write 1, old priv
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 new value
        {2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 EL0 write
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 flag kept
        {2'd2, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 imm clear
        {2'd2, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 host
        {2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 guest
        {2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        {2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 bad CRm
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 flag kept
        {2'd0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 EL0 imm
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 flag kept
        {2'd3, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 EL3 write
        {2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 EL3 read
        {2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 guest
        {2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 R6 EL0 read
        {2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 bad op2
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}  // R2 flag kept
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] el, input logic e2h, input logic tge,
                         input logic [1:0] kind, input logic ok, input logic val);
        el_i = el; e2h_i = e2h; tge_i = tge; acc_kind_i = kind;
        if (kind == 2'd2) begin
            op0_i = 2'd0; op1_i = 3'd0; crn_i = 4'd4;
            crm_i = {3'b101, val}; op2_i = ok ? 3'd3 : 3'd2;
        end else begin
            op0_i = 2'd3; op1_i = 3'd0; crn_i = 4'd4;
            crm_i = ok ? 4'd2 : 4'd3; op2_i = 3'd4;
        end
        wdata_i = val ? '1 : ~(64'd1 << 23);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, flag reads 0
        drive(2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        #2;
        check("R10 rdata", rdata_o, 64'd0);
        check("R10 priv", {63'd0, priv_o}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][10:9], VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3]);
            #2;
            check("R3 undef", {63'd0, undef_o}, {63'd0, VEC[i][2]});
            check("R4 rdata", rdata_o, {40'd0, VEC[i][1], 23'd0});
            check("R6 priv", {63'd0, priv_o}, {63'd0, VEC[i][0]});
        end

        // R9: feature absent, every matching access undefined
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        #2;
        check("R9 undef read", {63'd0, undef_off}, 64'd1);
        check("R9 rdata", rdata_off, 64'd0);
        check("R9 priv", {63'd0, priv_off}, 64'd0);
        @(negedge clk);
        drive(2'd3, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1);
        #2;
        check("R9 undef write", {63'd0, undef_off}, 64'd1);
        @(negedge clk);
        drive(2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1);
        #2;
        check("R9 undef imm", {63'd0, undef_off}, 64'd1);
        @(negedge clk);
        drive(2'd2, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0);
        #2;
        check("R9 flag stays 0", {63'd0, priv_off}, 64'd0);

        // R10: reset after flag set (flag is 1 on main instance here)
        @(negedge clk);
        rst_n = 1'b0;
        drive(2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        #2;
        check("R10 cleared rdata", rdata_o, 64'd0);
        check("R10 cleared priv", {63'd0, priv_o}, 64'd0);

        @(negedge clk);
        acc_kind_i = 2'd3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule